// File: doc/BRIEF.md
# Debug Data Transfer Mailbox

This block is a two-way word mailbox between an external debug host and a processor core. A 32-bit inbound register carries words from the host to the core. A 32-bit outbound register carries words from the core to the host. Each register has a full flag that tells the other side whether a word is waiting. The host reaches the mailbox through a simple register port that can arrive over a memory-mapped path or over an external path. The core reaches it through a system-register style port that can move 32 or 64 bits per access. A level interrupt tells the core that a word has arrived or that the outbound register has room.

On the host side, any access that has side-effects is checked against a three-bit status group (double-lock, OS-lock, powered-up). Failed accesses return an error response. Protocol errors are overrun, where the host writes an inbound word that has not been consumed, and underrun, where the host reads an outbound word that has not been produced. Each one sets its own flag and a sticky error flag. While the sticky flag is set, further host side-effects are suppressed. Only a dedicated clear strobe removes the error flags.

A 64-bit core access treats the two registers as one half-duplex channel:
- A 64-bit write puts the upper word in the inbound register and the lower word in the outbound register.
- A 64-bit read returns the outbound register in the upper word and the inbound register in the lower word.

Every value the protocol leaves undefined is driven as zero.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset, the inbound and outbound registers are zero and all flags are zero (inbound full, outbound full, sticky error, overrun, underrun).
- R2: `comm_irq` is high exactly when (inbound full AND `irq_en_rx`) OR (outbound empty AND `irq_en_tx`).
- R3: A host write to the inbound register (`hst_sel`=0) or a host read of the outbound register (`hst_sel`=1) is checked against `pwr_stat` = {double-lock, OS-lock, powered-up}. If `pwr_stat` is not 3'b001, `hst_slverr` is high, `hst_rdata` is zero and no state changes.
- R4: A permitted host write to the inbound register loads the data and sets inbound full. This applies when inbound is empty, there is no sticky error and there is no lock. Host reads of the inbound register return its contents and have no side-effect.
- R5: A permitted host write to the inbound register while it is full sets the overrun flag and the sticky error flag, and discards the data.
- R6: A permitted host read of the outbound register while it is full returns the register and clears outbound full.
- R7: A permitted host read of the outbound register while it is empty returns zero and sets the underrun flag and the sticky error flag.
- R8: While the sticky error flag is set, host inbound writes are ignored. Host outbound reads return the register if it is full and zero if it is empty, and change no flag.
- R9: When `sw_lock` is high, an access with `hst_mmap`=1 has no side-effect, and that includes host writes to the outbound register. Accesses with `hst_mmap`=0 are unaffected.
- R10: A host write to the outbound register stores the value and changes no flag. It is blocked only by R9.
- R11: A core write sets outbound full. A 32-bit write loads the outbound register from bits 31:0. A 64-bit write loads the inbound register from bits 63:32 and the outbound register from bits 31:0. If outbound full was already set, the written registers receive zero.
- R12: A core read clears inbound full. It returns {outbound, inbound} when 64-bit and {32'b0, inbound} when 32-bit, or all zeros if inbound full was clear.
- R13: `hst_err_clr` clears the sticky error, overrun and underrun flags. An error raised in the same cycle as the strobe wins, and the flag stays set.
- R14: When a host access and a core access fall in the same cycle, both are applied. Where they update the same flag or register, the core's update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_stat | input | 3 | {double-lock, OS-lock, powered-up} status group |
| sw_lock | input | 1 | Software lock; applies to memory-mapped host accesses |
| hst_req | input | 1 | Host access strobe, one cycle per access |
| hst_wr | input | 1 | 1 = host write, 0 = host read |
| hst_sel | input | 1 | 0 = inbound register, 1 = outbound register |
| hst_mmap | input | 1 | 1 = access came over the memory-mapped path |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid in the request cycle |
| hst_slverr | output | 1 | Error response, valid in the request cycle |
| hst_err_clr | input | 1 | Clears the error flags |
| cor_req | input | 1 | Core access strobe |
| cor_wr | input | 1 | 1 = core write, 0 = core read |
| cor_wide | input | 1 | 1 = 64-bit access |
| cor_wdata | input | 64 | Core write data |
| cor_rdata | output | 64 | Core read data, valid in the request cycle |
| irq_en_rx | input | 1 | Enables the inbound-full interrupt |
| irq_en_tx | input | 1 | Enables the outbound-empty interrupt |
| rx_full | output | 1 | Inbound full flag |
| tx_full | output | 1 | Outbound full flag |
| err_flag | output | 1 | Sticky error flag |
| rx_ovr | output | 1 | Inbound overrun flag |
| tx_udr | output | 1 | Outbound underrun flag |
| comm_irq | output | 1 | Level interrupt to the core |

## Verification
The host port and the core port can act on the same full flag in one clock. A host inbound write can meet a core read, and a host outbound read can meet a core write. A new error can also meet the clear strobe. The bench drives both strobes from one task in the same cycle. It then judges the result by the flags after the edge, and by what later host reads and core reads return.

// File: rtl/dbgmb_pkg.sv
// Shared types for the debug mailbox.
// Assumes a 32-bit word; the core port is two words wide.
package dbgmb_pkg;
    localparam int WORD_W = 32;

    // Actions decoded from one host access
    typedef struct packed {
        logic rx_load;
        logic ovr_set;
        logic udr_set;
        logic tx_clr;
        logic tx_load;
    } host_act_t;

    // Actions decoded from one core access
    typedef struct packed {
        logic rx_clr;
        logic tx_set;
        logic rx_ld;
        logic tx_ld;
    } core_act_t;
endpackage

// File: rtl/dbgmb_host_gate.sv
// Host access decoder: applies the permission, sticky-error and
// software-lock checks and turns one host access into state actions.
// Assumes at most one host access per cycle; purely combinational.
module dbgmb_host_gate
    import dbgmb_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  logic          req,
    input  logic          wr,
    input  logic          sel,
    input  logic          mmap,
    input  logic [2:0]    pwr_stat,
    input  logic          sw_lock,
    input  logic          err,
    input  logic          rx_full,
    input  logic          tx_full,
    input  logic [DW-1:0] rx_reg,
    input  logic [DW-1:0] tx_reg,
    output logic [DW-1:0] rdata,
    output logic          slverr,
    output host_act_t     act
);
    localparam logic [2:0] PERM_OK = 3'b001;

    logic checked;
    logic perm_ok;
    logic locked;

    // Classify the access and evaluate the gates
    always_comb begin
        checked = req && (wr ? !sel : sel);
        perm_ok = (pwr_stat == PERM_OK);
        locked  = mmap && sw_lock;
    end

    // Decode response and actions
    always_comb begin
        rdata  = '0;
        slverr = 1'b0;
        act    = '0;
        if (req) begin
            if (checked && !perm_ok) begin
                slverr = 1'b1;
            end else if (wr && !sel) begin
                if (!err && !locked) begin
                    if (rx_full) act.ovr_set = 1'b1;
                    else         act.rx_load = 1'b1;
                end
            end else if (wr && sel) begin
                act.tx_load = !locked;
            end else if (!wr && !sel) begin
                rdata = rx_reg;
            end else begin
                rdata = tx_full ? tx_reg : '0;
                if (!err && !locked) begin
                    if (tx_full) act.tx_clr  = 1'b1;
                    else         act.udr_set = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dbgmb_core_port.sv
// Core access decoder: 32/64-bit reads and writes over the two data
// registers as a half-duplex channel. Undefined results are zero.
// Assumes at most one core access per cycle; purely combinational.
module dbgmb_core_port
    import dbgmb_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  logic            req,
    input  logic            wr,
    input  logic            wide,
    input  logic [2*DW-1:0] wdata,
    input  logic            rx_full,
    input  logic            tx_full,
    input  logic [DW-1:0]   rx_reg,
    input  logic [DW-1:0]   tx_reg,
    output logic [2*DW-1:0] rdata,
    output logic [DW-1:0]   rx_val,
    output logic [DW-1:0]   tx_val,
    output core_act_t       act
);
    // Decode writes: load targets and values
    always_comb begin
        act        = '0;
        rx_val     = tx_full ? '0 : wdata[2*DW-1:DW];
        tx_val     = tx_full ? '0 : wdata[DW-1:0];
        act.tx_set = req && wr;
        act.tx_ld  = req && wr;
        act.rx_ld  = req && wr && wide;
        act.rx_clr = req && !wr;
    end

    // Build read data
    always_comb begin
        rdata = '0;
        if (req && !wr && rx_full) begin
            rdata[DW-1:0] = rx_reg;
            if (wide) rdata[2*DW-1:DW] = tx_reg;
        end
    end
endmodule

// File: rtl/dbgmb_state.sv
// Mailbox state: two data registers and five flags. Merges host and
// core actions; the core's update wins where both touch one item.
// Assumes synchronous active-low reset.
module dbgmb_state
    import dbgmb_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  host_act_t     h_act,
    input  logic [DW-1:0] h_wdata,
    input  logic          err_clr,
    input  core_act_t     c_act,
    input  logic [DW-1:0] c_rx_val,
    input  logic [DW-1:0] c_tx_val,
    output logic [DW-1:0] rx_reg,
    output logic [DW-1:0] tx_reg,
    output logic          rx_full,
    output logic          tx_full,
    output logic          err,
    output logic          ovr,
    output logic          udr
);
    // Data registers, core write first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_reg <= '0;
            tx_reg <= '0;
        end else begin
            if (c_act.rx_ld)        rx_reg <= c_rx_val;
            else if (h_act.rx_load) rx_reg <= h_wdata;
            if (c_act.tx_ld)        tx_reg <= c_tx_val;
            else if (h_act.tx_load) tx_reg <= h_wdata;
        end
    end

    // Full flags, core update first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_full <= 1'b0;
            tx_full <= 1'b0;
        end else begin
            if (c_act.rx_clr)       rx_full <= 1'b0;
            else if (h_act.rx_load) rx_full <= 1'b1;
            if (c_act.tx_set)       tx_full <= 1'b1;
            else if (h_act.tx_clr)  tx_full <= 1'b0;
        end
    end

    // Error flags: a new error beats the clear strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
            ovr <= 1'b0;
            udr <= 1'b0;
        end else begin
            err <= (err && !err_clr) || h_act.ovr_set || h_act.udr_set;
            ovr <= (ovr && !err_clr) || h_act.ovr_set;
            udr <= (udr && !err_clr) || h_act.udr_set;
        end
    end
endmodule

// File: rtl/dbgmb_irq.sv
// Interrupt level: inbound word waiting or outbound room, each enabled
// separately. Assumes flags come from registers; combinational output.
module dbgmb_irq (
    input  logic rx_full,
    input  logic tx_full,
    input  logic en_rx,
    input  logic en_tx,
    output logic irq
);
    // Combine the two enabled sources
    always_comb irq = (rx_full && en_rx) || (!tx_full && en_tx);
endmodule

// File: rtl/dbg_mailbox.sv
// Debug data transfer mailbox top: host register port, core
// system-register port, flags and interrupt. Responses on both ports
// are combinational in the request cycle; state updates on the edge.
module dbg_mailbox
    import dbgmb_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      pwr_stat,
    input  logic            sw_lock,
    input  logic            hst_req,
    input  logic            hst_wr,
    input  logic            hst_sel,
    input  logic            hst_mmap,
    input  logic [DW-1:0]   hst_wdata,
    output logic [DW-1:0]   hst_rdata,
    output logic            hst_slverr,
    input  logic            hst_err_clr,
    input  logic            cor_req,
    input  logic            cor_wr,
    input  logic            cor_wide,
    input  logic [2*DW-1:0] cor_wdata,
    output logic [2*DW-1:0] cor_rdata,
    input  logic            irq_en_rx,
    input  logic            irq_en_tx,
    output logic            rx_full,
    output logic            tx_full,
    output logic            err_flag,
    output logic            rx_ovr,
    output logic            tx_udr,
    output logic            comm_irq
);
    host_act_t     h_act;
    core_act_t     c_act;
    logic [DW-1:0] rx_reg;
    logic [DW-1:0] tx_reg;
    logic [DW-1:0] c_rx_val;
    logic [DW-1:0] c_tx_val;

    dbgmb_host_gate #(.DW(DW)) u_host (
        .req(hst_req), .wr(hst_wr), .sel(hst_sel), .mmap(hst_mmap),
        .pwr_stat(pwr_stat), .sw_lock(sw_lock), .err(err_flag),
        .rx_full(rx_full), .tx_full(tx_full), .rx_reg(rx_reg),
        .tx_reg(tx_reg), .rdata(hst_rdata), .slverr(hst_slverr),
        .act(h_act)
    );

    dbgmb_core_port #(.DW(DW)) u_core (
        .req(cor_req), .wr(cor_wr), .wide(cor_wide), .wdata(cor_wdata),
        .rx_full(rx_full), .tx_full(tx_full), .rx_reg(rx_reg),
        .tx_reg(tx_reg), .rdata(cor_rdata), .rx_val(c_rx_val),
        .tx_val(c_tx_val), .act(c_act)
    );

    dbgmb_state #(.DW(DW)) u_state (
        .clk(clk), .rst_n(rst_n), .h_act(h_act), .h_wdata(hst_wdata),
        .err_clr(hst_err_clr), .c_act(c_act), .c_rx_val(c_rx_val),
        .c_tx_val(c_tx_val), .rx_reg(rx_reg), .tx_reg(tx_reg),
        .rx_full(rx_full), .tx_full(tx_full), .err(err_flag),
        .ovr(rx_ovr), .udr(tx_udr)
    );

    dbgmb_irq u_irq (
        .rx_full(rx_full), .tx_full(tx_full), .en_rx(irq_en_rx),
        .en_tx(irq_en_tx), .irq(comm_irq)
    );
endmodule

// File: rtl/dbgmb_checker.sv
// Protocol checker for the debug mailbox, attached with bind.
module dbgmb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] pwr_stat,
    input logic       sw_lock,
    input logic       hst_req,
    input logic       hst_wr,
    input logic       hst_sel,
    input logic       hst_mmap,
    input logic       hst_slverr,
    input logic       hst_err_clr,
    input logic       cor_req,
    input logic       cor_wr,
    input logic       rx_full,
    input logic       tx_full,
    input logic       err_flag,
    input logic       rx_ovr,
    input logic       tx_udr
);
    logic gated_acc;
    logic open_acc;
    always_comb begin
        gated_acc = hst_req && (hst_wr ? !hst_sel : hst_sel);
        open_acc  = gated_acc && pwr_stat == 3'b001 && !err_flag
                    && !(hst_mmap && sw_lock) && !cor_req;
    end

    // R3
    perm_denied_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gated_acc && pwr_stat != 3'b001) |-> hst_slverr);

    // R3
    perm_denied_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gated_acc && pwr_stat != 3'b001 && !cor_req && !hst_err_clr)
        |=> ($stable(rx_full) && $stable(tx_full) && $stable(err_flag)));

    // R5
    rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_acc && hst_wr && rx_full) |=> (err_flag && rx_ovr && rx_full));

    // R7
    tx_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_acc && !hst_wr && !tx_full) |=> (err_flag && tx_udr));

    // R8
    sticky_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !hst_err_clr && hst_req && !cor_req)
        |=> ($stable(rx_full) && $stable(tx_full) && err_flag));

    // R11
    core_wr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cor_req && cor_wr) |=> tx_full);

    // R12
    core_rd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cor_req && !cor_wr) |=> !rx_full);

    // R13
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(hst_req));
endmodule

bind dbg_mailbox dbgmb_checker u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_stat(pwr_stat), .sw_lock(sw_lock),
    .hst_req(hst_req), .hst_wr(hst_wr), .hst_sel(hst_sel),
    .hst_mmap(hst_mmap), .hst_slverr(hst_slverr),
    .hst_err_clr(hst_err_clr), .cor_req(cor_req), .cor_wr(cor_wr),
    .rx_full(rx_full), .tx_full(tx_full), .err_flag(err_flag),
    .rx_ovr(rx_ovr), .tx_udr(tx_udr)
);

// File: tb/tb_dbg_mailbox.sv
// Directed bench for the debug mailbox: one task per scenario.
module tb_dbg_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  pwr_stat = 3'b001;
    logic        sw_lock = 1'b0;
    logic        hst_req = 1'b0, hst_wr = 1'b0, hst_sel = 1'b0, hst_mmap = 1'b0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        hst_slverr;
    logic        hst_err_clr = 1'b0;
    logic        cor_req = 1'b0, cor_wr = 1'b0, cor_wide = 1'b0;
    logic [63:0] cor_wdata = '0;
    logic [63:0] cor_rdata;
    logic        irq_en_rx = 1'b0, irq_en_tx = 1'b0;
    logic        rx_full, tx_full, err_flag, rx_ovr, tx_udr, comm_irq;

    int checks = 0;
    int fails = 0;
    logic [31:0] h_rd;
    logic        h_se;
    logic [63:0] c_rd;

    always #2 clk = ~clk;

    dbg_mailbox dut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sample responses mid-cycle, then pass the edge and drop strobes
    task automatic step();
        #1;
        h_rd = hst_rdata; h_se = hst_slverr; c_rd = cor_rdata;
        @(negedge clk);
        hst_req = 1'b0; cor_req = 1'b0; hst_err_clr = 1'b0;
    endtask

    task automatic h_set(input logic wr, input logic sel, input logic mm, input logic [31:0] d);
        hst_req = 1'b1; hst_wr = wr; hst_sel = sel; hst_mmap = mm; hst_wdata = d;
    endtask

    task automatic c_set(input logic wr, input logic wide, input logic [63:0] d);
        cor_req = 1'b1; cor_wr = wr; cor_wide = wide; cor_wdata = d;
    endtask

    task automatic host(input logic wr, input logic sel, input logic mm, input logic [31:0] d);
        h_set(wr, sel, mm, d); step();
    endtask

    task automatic core(input logic wr, input logic wide, input logic [63:0] d);
        c_set(wr, wide, d); step();
    endtask

    task automatic clear_err();
        hst_err_clr = 1'b1; step();
    endtask

    task automatic t_reset();
        check("R1 rx_full", rx_full, 0);
        check("R1 tx_full", tx_full, 0);
        check("R1 flags", {err_flag, rx_ovr, tx_udr}, 0);
        host(0, 0, 0, 0);
        check("R1 rx reg", h_rd, 0);
        check("R2 irq off", comm_irq, 0);
        irq_en_tx = 1'b1; #1;
        check("R2 tx empty irq", comm_irq, 1);
        irq_en_tx = 1'b0; @(negedge clk);
    endtask

    task automatic t_rx_path();
        irq_en_rx = 1'b1;
        host(1, 0, 1, 32'hA5A5_0001);
        check("R4 rx_full set", rx_full, 1);
        check("R2 rx irq", comm_irq, 1);
        host(0, 0, 1, 0);
        check("R4 rx read", h_rd, 32'hA5A5_0001);
        check("R4 no side effect", rx_full, 1);
        core(0, 0, 0);
        check("R12 core rd32", c_rd, 64'h0000_0000_A5A5_0001);
        check("R12 rx_full clr", rx_full, 0);
        check("R2 irq drop", comm_irq, 0);
        core(0, 1, 0);
        check("R12 empty read zero", c_rd, 0);
        irq_en_rx = 1'b0;
    endtask

    task automatic t_overrun();
        host(1, 0, 0, 32'h1111_0000);
        host(1, 0, 0, 32'h2222_0000);
        check("R5 flags", {err_flag, rx_ovr, tx_udr}, 3'b110);
        core(0, 0, 0);
        check("R5 data kept", c_rd, 64'h1111_0000);
        clear_err();
        check("R13 cleared", {err_flag, rx_ovr, tx_udr}, 0);
    endtask

    task automatic t_tx_path();
        core(1, 0, 64'hFFFF_FFFF_0D0D_0D0D);
        check("R11 tx_full", tx_full, 1);
        check("R11 rx untouched", rx_full, 0);
        host(0, 1, 0, 0);
        check("R6 tx read", h_rd, 32'h0D0D_0D0D);
        check("R6 tx_full clr", tx_full, 0);
        host(0, 1, 0, 0);
        check("R7 underrun data", h_rd, 0);
        check("R7 flags", {err_flag, rx_ovr, tx_udr}, 3'b101);
        clear_err();
    endtask

    task automatic t_wide();
        core(1, 1, 64'hEEEE_0001_FFFF_0002);
        host(0, 0, 0, 0);
        check("R11 wide hi to rx", h_rd, 32'hEEEE_0001);
        check("R11 rx_full unchanged", rx_full, 0);
        host(0, 1, 0, 0);
        check("R11 wide lo to tx", h_rd, 32'hFFFF_0002);
        core(1, 0, 64'h3333);
        core(1, 1, 64'h4444_4444_5555_5555);
        host(0, 0, 0, 0);
        check("R11 full -> rx zero", h_rd, 0);
        host(0, 1, 0, 0);
        check("R11 full -> tx zero", h_rd, 0);
        host(1, 0, 0, 32'h6666_0006);
        host(1, 1, 0, 32'h7777_0007);
        check("R10 no flag change", tx_full, 0);
        core(0, 1, 0);
        check("R12 wide read order", c_rd, 64'h7777_0007_6666_0006);
    endtask

    task automatic t_perm();
        pwr_stat = 3'b011;
        host(1, 0, 0, 32'h9);
        check("R3 slverr wr", h_se, 1);
        check("R3 no load", rx_full, 0);
        core(1, 0, 64'h1234);
        host(0, 1, 0, 0);
        check("R3 slverr rd", h_se, 1);
        check("R3 rd zero", h_rd, 0);
        check("R3 tx kept", tx_full, 1);
        pwr_stat = 3'b000;
        host(0, 1, 0, 0);
        check("R3 unpowered", {h_se, tx_full}, 2'b11);
        pwr_stat = 3'b001;
        host(0, 1, 0, 0);
        check("R3 permitted", {h_se, h_rd}, 33'h0_0000_1234);
    endtask

    task automatic t_sticky();
        host(0, 1, 0, 0);
        check("R7 err set", err_flag, 1);
        host(1, 0, 0, 32'hBAD);
        check("R8 rx write ignored", rx_full, 0);
        core(1, 0, 64'h5678);
        host(0, 1, 0, 0);
        check("R8 read value", h_rd, 32'h5678);
        check("R8 tx_full kept", tx_full, 1);
        clear_err();
        host(0, 1, 0, 0);
    endtask

    task automatic t_lock();
        sw_lock = 1'b1;
        host(1, 0, 1, 32'hC0);
        check("R9 mmap rx ignored", rx_full, 0);
        host(1, 0, 0, 32'hC1);
        check("R9 ext rx loads", rx_full, 1);
        core(0, 0, 0);
        check("R9 ext data", c_rd, 64'hC1);
        core(1, 0, 64'hD0);
        host(1, 1, 1, 32'hD1);
        host(0, 1, 1, 0);
        check("R9 mmap tx write ignored", h_rd, 32'hD0);
        check("R9 mmap read no clear", tx_full, 1);
        host(0, 1, 1, 0);
        check("R9 mmap no underrun", err_flag, 0);
        host(0, 1, 0, 0);
        check("R9 ext read clears", tx_full, 0);
        sw_lock = 1'b0;
    endtask

    task automatic t_same_cycle();
        h_set(1, 0, 0, 32'hAB); c_set(0, 0, 0); step();
        check("R14 core rd beats rx load", rx_full, 0);
        check("R14 empty rd zero", c_rd, 0);
        host(0, 0, 0, 0);
        check("R14 host data applied", h_rd, 32'hAB);
        core(1, 0, 64'hCD);
        h_set(0, 1, 0, 0); c_set(1, 0, 64'hEF); step();
        check("R14 host rd old value", h_rd, 32'hCD);
        check("R14 core set beats clear", tx_full, 1);
        host(0, 1, 0, 0);
        check("R14 tx value zero", h_rd, 0);
        h_set(0, 1, 0, 0); hst_err_clr = 1'b1; step();
        check("R13 set beats clear", {err_flag, tx_udr}, 2'b11);
        clear_err();
        check("R13 clear", err_flag, 0);
    endtask

    initial begin
        #(200_000 * 4);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_path();
        t_overrun();
        t_tx_path();
        t_wide();
        t_perm();
        t_sticky();
        t_lock();
        t_same_cycle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule